// File: doc/BRIEF.md
# Iterative Integer Multiply, Divide and Remainder Unit

This block is a multi-cycle arithmetic engine that sits beside the integer pipeline of a 32-bit core. A request carries two operands and a 3-bit operation code. The unit produces one result word for each request. The operations are: the low word of a signed product, signed and unsigned quotient, and signed and unsigned remainder. The unit has no high/low result pair, so every operation yields exactly one word. No operation traps or flags an overflow. Division by zero and the most-negative-over-minus-one case give fixed, defined values.

The multiplier adds and shifts one operand bit per cycle. The divider is a restoring divider that produces one quotient bit per cycle and works on operand magnitudes. A single sign-fix cycle then applies the signs. A state machine steps through four named states:

- `ST_IDLE`: request ready is high. A valid request moves the machine to `ST_RUN` and loads both datapaths.
- `ST_RUN`: runs exactly `W` iterations. The last one moves to `ST_FIX`.
- `ST_FIX`: selects and registers the result, then always moves to `ST_DONE`.
- `ST_DONE`: response valid is high. A response handshake moves back to `ST_IDLE`.

Only one operation is in flight at a time.

Top module: `imd_unit`

## Requirements
- R1: Immediately after reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Op code 0 returns bits [W-1:0] of the signed product of `req_a` and `req_b`.
- R3: Op code 1 returns the signed quotient, rounded toward zero. Op code 3 returns the signed remainder, which takes the sign of the dividend.
- R4: Op code 2 returns the unsigned quotient and op code 4 the unsigned remainder, with both operands read as unsigned.
- R5: A divisor of zero gives a quotient of all ones (op codes 1 and 2) and a remainder equal to the dividend (op codes 3 and 4).
- R6: Signed division of 0x80000000 by 0xFFFFFFFF gives a quotient of 0x80000000 (op code 1) and a remainder of 0 (op code 3), with no trap.
- R7: `req_ready` drops on the edge that accepts a request. It stays low until the response is consumed, and is high again on the following cycle. Requests presented while it is low have no effect on the pending result.
- R8: `rsp_valid` first shows high W+1 clock edges after the accepting edge.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` does not change.
- R10: Op codes 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Operation code (0 mul, 1 div, 2 divu, 3 rem, 4 remu) |
| req_a | input | W (32) | First operand / dividend |
| req_b | input | W (32) | Second operand / divisor |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | W (32) | Result word |

## Verification
Two things can happen close together: a new request can arrive while an earlier result is still owed or is stalled at the output. The bench provokes this by raising `req_valid` with different operands in the middle of an operation and keeping it up until the result appears. It then holds the response back with `rsp_ready` low for a random number of cycles. The check is that the delivered word still matches the first request and does not move while stalled. It also checks that `req_ready` returns only on the cycle after the pop. Random operations from a fixed seed are mixed with directed cases for divide by zero, the signed overflow quotient and sign combinations. All results are compared against bench functions.

// File: rtl/imd_pkg.sv
package imd_pkg;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_DIV  = 3'd1,
        OP_DIVU = 3'd2,
        OP_REM  = 3'd3,
        OP_REMU = 3'd4
    } imd_op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } imd_state_t;

    function automatic logic op_is_signed(input logic [2:0] op);
        return (op == OP_DIV) || (op == OP_REM);
    endfunction

endpackage

// File: rtl/imd_mul_core.sv
module imd_mul_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_lo
);
    // Low word of a two's-complement product equals the low word of the
    // unsigned product, so a plain shift-add over W bits suffices.
    logic [W-1:0] acc_q;
    logic [W-1:0] mcand_q;
    logic [W-1:0] mplier_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            acc_q    <= '0;
            mcand_q  <= a;
            mplier_q <= b;
        end else if (step) begin
            if (mplier_q[0]) begin
                acc_q <= acc_q + mcand_q;
            end
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign prod_lo = acc_q;

endmodule

// File: rtl/imd_div_core.sv
module imd_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] quo_q;
    logic [W-1:0] part_q;
    logic [W-1:0] dvs_q;
    logic [W-1:0] dvd_q;
    logic         neg_quo_q;
    logic         neg_rem_q;
    logic         zero_q;

    logic [W-1:0] a_mag;
    logic [W-1:0] b_mag;
    logic [W:0]   shifted;
    logic [W:0]   trial;

    always_comb begin
        a_mag   = (sgn && a[W-1]) ? (~a + 1'b1) : a;
        b_mag   = (sgn && b[W-1]) ? (~b + 1'b1) : b;
        shifted = {part_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q     <= '0;
            part_q    <= '0;
            dvs_q     <= '0;
            dvd_q     <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            zero_q    <= 1'b0;
        end else if (load) begin
            quo_q     <= a_mag;
            part_q    <= '0;
            dvs_q     <= b_mag;
            dvd_q     <= a;
            neg_quo_q <= sgn && (a[W-1] ^ b[W-1]);
            neg_rem_q <= sgn && a[W-1];
            zero_q    <= (b == '0);
        end else if (step) begin
            if (!trial[W]) begin
                part_q <= trial[W-1:0];
                quo_q  <= {quo_q[W-2:0], 1'b1};
            end else begin
                part_q <= shifted[W-1:0];
                quo_q  <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        if (zero_q) begin
            quo_o = '1;
            rem_o = dvd_q;
        end else begin
            quo_o = neg_quo_q ? (~quo_q + 1'b1) : quo_q;
            rem_o = neg_rem_q ? (~part_q + 1'b1) : part_q;
        end
    end

endmodule

// File: rtl/imd_ctrl.sv
module imd_ctrl
    import imd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [2:0]   req_op,
    input  logic         rsp_ready,
    input  logic [W-1:0] mul_res,
    input  logic [W-1:0] quo_res,
    input  logic [W-1:0] rem_res,
    output logic         req_ready,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data,
    output logic         load,
    output logic         step
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    imd_state_t   state_q;
    imd_state_t   state_d;
    logic [CW-1:0] iter_q;
    logic [2:0]    op_q;
    logic [W-1:0]  res_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)          state_d = ST_RUN;
            ST_RUN:  if (iter_q == LAST)     state_d = ST_FIX;
            ST_FIX:                          state_d = ST_DONE;
            ST_DONE: if (rsp_ready)          state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_DONE);
        load      = (state_q == ST_IDLE) && req_valid;
        step      = (state_q == ST_RUN);
        rsp_data  = res_q;
    end

    // iteration count, latched op and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q <= '0;
            op_q   <= '0;
            res_q  <= '0;
        end else begin
            if (load) begin
                iter_q <= '0;
                op_q   <= req_op;
            end else if (step) begin
                iter_q <= iter_q + 1'b1;
            end
            if (state_q == ST_FIX) begin
                case (op_q)
                    OP_MUL:           res_q <= mul_res;
                    OP_DIV, OP_DIVU:  res_q <= quo_res;
                    OP_REM, OP_REMU:  res_q <= rem_res;
                    default:          res_q <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/imd_unit.sv
module imd_unit
    import imd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [2:0]   req_op,
    input  logic [W-1:0] req_a,
    input  logic [W-1:0] req_b,
    output logic         rsp_valid,
    input  logic         rsp_ready,
    output logic [W-1:0] rsp_data
);
    logic         load;
    logic         step;
    logic         sgn;
    logic [W-1:0] mul_res;
    logic [W-1:0] quo_res;
    logic [W-1:0] rem_res;

    assign sgn = op_is_signed(req_op);

    imd_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .rsp_ready (rsp_ready),
        .mul_res   (mul_res),
        .quo_res   (quo_res),
        .rem_res   (rem_res),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .load      (load),
        .step      (step)
    );

    imd_mul_core #(.W(W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .a       (req_a),
        .b       (req_b),
        .prod_lo (mul_res)
    );

    imd_div_core #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .sgn   (sgn),
        .a     (req_a),
        .b     (req_b),
        .quo_o (quo_res),
        .rem_o (rem_res)
    );

endmodule

// File: rtl/imd_unit_chk.sv
module imd_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_ready,
    input logic [2:0]   req_op,
    input logic [W-1:0] req_a,
    input logic [W-1:0] req_b,
    input logic         rsp_valid,
    input logic         rsp_ready,
    input logic [W-1:0] rsp_data
);
    localparam int LW = $clog2(W + 8) + 1;

    logic [LW-1:0] lat_q;
    logic [2:0]    cap_op;
    logic [W-1:0]  cap_a;
    logic [W-1:0]  cap_b;
    logic [W-1:0]  exp_mul;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            cap_op <= '0;
            cap_a  <= '0;
            cap_b  <= '0;
        end else if (req_valid && req_ready) begin
            lat_q  <= LW'(1);
            cap_op <= req_op;
            cap_a  <= req_a;
            cap_b  <= req_b;
        end else if (lat_q != '0 && !rsp_valid) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    assign exp_mul = cap_a * cap_b;

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_READY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid)); // R7

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9

    // counter counts the accept edge plus W+1 edges before the rise is sampled
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (lat_q == LW'(W + 2))); // R8

    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && (cap_op == 3'd1 || cap_op == 3'd2) && cap_b == '0)
        |-> (rsp_data == '1)); // R5

    AST_MUL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && cap_op == 3'd0) |-> (rsp_data == exp_mul)); // R2

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && cap_op > 3'd4) |-> (rsp_data == '0)); // R10

endmodule

bind imd_unit imd_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_a     (req_a),
    .req_b     (req_b),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
);

// File: tb/tb_imd_unit.sv
`timescale 1ns/1ps
module tb_imd_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_op = '0;
    logic [W-1:0] req_a = '0;
    logic [W-1:0] req_b = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic [W-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    imd_unit #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_a     (req_a),
        .req_b     (req_b),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic signed [W-1:0] sa;
        logic signed [W-1:0] sb;
        logic [W-1:0] minv;
        sa = a;
        sb = b;
        minv = {1'b1, {(W-1){1'b0}}};
        case (op)
            3'd0: return a * b;
            3'd1: begin
                if (b == '0) return '1;
                if (a == minv && b == '1) return minv;
                return sa / sb;
            end
            3'd2: return (b == '0) ? '1 : a / b;
            3'd3: begin
                if (b == '0) return a;
                if (a == minv && b == '1) return '0;
                return sa % sb;
            end
            3'd4: return (b == '0) ? a : a % b;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [W-1:0] a,
                                     input logic [W-1:0] b);
        if (op > 3'd4) return "R10 undefined op";
        if (op == 3'd0) return "R2 mul";
        if (b == '0) return "R5 divide by zero";
        if ((op == 3'd1 || op == 3'd3) && a == 32'h8000_0000 && b == '1) return "R6 overflow case";
        if (op == 3'd1 || op == 3'd3) return "R3 signed div/rem";
        return "R4 unsigned div/rem";
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit stray);
        int n;
        int hold;
        logic [W-1:0] first;
        @(negedge clk);
        check("R7 ready before request", W'(req_ready), W'(1));
        req_valid = 1'b1;
        req_op = op;
        req_a = a;
        req_b = b;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 ready low after accept", W'(req_ready), W'(0));
        n = 0;
        while (!rsp_valid && n < 200) begin
            if (stray && n == 3) begin
                req_valid = 1'b1;
                req_op = 3'd0;
                req_a = ~a;
                req_b = b + 32'd5;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check("R8 latency", W'(n), W'(W + 1));
        check(tag_of(op, a, b), rsp_data, model(op, a, b));
        if (stray) check("R7 stray request ignored", rsp_data, model(op, a, b));
        first = rsp_data;
        hold = $urandom_range(0, 3);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R9 held valid", W'(rsp_valid), W'(1));
            check("R9 held data", rsp_data, first);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R7 ready after pop", W'(req_ready), W'(1));
        check("R7 valid cleared after pop", W'(rsp_valid), W'(0));
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready", W'(req_ready), W'(1));
        check("R1 reset valid", W'(rsp_valid), W'(0));

        run_op(3'd0, 32'hFFFF_FFFD, 32'd7, 1'b0);          // R2 -3*7
        run_op(3'd0, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);  // R2 wrap
        run_op(3'd1, 32'hFFFF_FFF9, 32'd2, 1'b0);          // R3 -7/2 = -3
        run_op(3'd3, 32'hFFFF_FFF9, 32'd2, 1'b0);          // R3 -7%2 = -1
        run_op(3'd3, 32'd7, 32'hFFFF_FFFE, 1'b1);          // R3 7%-2 = 1
        run_op(3'd1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b0);  // R3 -7/-2 = 3
        run_op(3'd2, 32'hFFFF_FFFF, 32'd2, 1'b0);          // R4
        run_op(3'd4, 32'hFFFF_FFFF, 32'd10, 1'b0);         // R4
        run_op(3'd1, 32'hFFFF_FF00, 32'd0, 1'b0);          // R5
        run_op(3'd2, 32'd77, 32'd0, 1'b0);                 // R5
        run_op(3'd3, 32'hFFFF_FF00, 32'd0, 1'b1);          // R5
        run_op(3'd4, 32'd77, 32'd0, 1'b0);                 // R5
        run_op(3'd1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);  // R6
        run_op(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);  // R6
        run_op(3'd5, 32'd9, 32'd3, 1'b0);                  // R10
        run_op(3'd6, 32'd9, 32'd3, 1'b0);                  // R10
        run_op(3'd7, 32'd9, 32'd3, 1'b1);                  // R10

        for (int k = 0; k < 60; k++) begin
            logic [2:0] op;
            logic [W-1:0] a;
            logic [W-1:0] b;
            op = 3'($urandom_range(0, 4));
            a = $urandom();
            b = $urandom();
            if ((k % 4) == 1) b = W'($urandom_range(0, 9)) - W'(3);
            run_op(op, a, b, (k % 3) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule